// File: doc/BRIEF.md
# PS/2 Pointing-Device Command Responder

This block stands in for the command-handling side of a PS/2 mouse. A controller forwards command bytes to it one at a time. The block keeps the device configuration: a status byte holding the scaling flag and the reporting flag, a resolution byte and a sample-rate byte. It answers each command with a short, ordered burst of response bytes. The burst goes out on a valid/ready push port that feeds the auxiliary output queue.

Two commands take a parameter. These are set-resolution (0xE8) and set-sample-rate (0xF3). After acknowledging one of them, the block treats the next forwarded byte as the value to store and does not decode it as a command. While a burst is still draining, the command port is held not ready. When the queue deasserts ready, the block waits with its current byte held.

Top module: `ps2_mouse_responder`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `rsp_valid` is 0. The configuration is status 0x00, resolution 0x02 and sample rate 0x64 (100).
- R2: The first response byte for every accepted byte is 0xFA. This covers commands and parameter bytes alike. It appears on the cycle after acceptance.
- R3: Command 0xE6 clears status bit 4 (scaling). It leaves the other status bits unchanged and replies 0xFA only.
- R4: Command 0xE9 replies with four bytes, in order: 0xFA, the status byte, the resolution, then the sample rate.
- R5: Command 0xF2 replies 0xFA, then the device identifier 0x00.
- R6: Command 0xF4 sets status bit 5 (reporting enabled). Command 0xF5 clears that bit. Each replies 0xFA only.
- R7: Commands 0xF6 and 0xFF each restore status 0x00, resolution 0x02 and sample rate 0x64, and reply 0xFA only.
- R8: After 0xE8 or 0xF3 is accepted, the next accepted byte is stored whole as the resolution or the sample rate respectively. That byte is not decoded as a command and is answered 0xFA only.
- R9: Any other command byte replies 0xFA only and changes no configuration.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_byte` stays unchanged. `cmd_ready` is 0 whenever response bytes are pending, so command bytes offered then are not taken.
- R11: With `rsp_ready` held at 1, the bytes of a burst appear on consecutive cycles, one per cycle. `rsp_valid` drops on the cycle after the last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A forwarded command or parameter byte is offered |
| cmd_ready | output | 1 | The block can take a byte (no response pending) |
| cmd_byte | input | 8 | Forwarded command or parameter byte |
| rsp_valid | output | 1 | A response byte is presented |
| rsp_ready | input | 1 | The auxiliary queue accepts the presented byte |
| rsp_byte | output | 8 | Response byte |

## Verification
Several properties are checked on every cycle. The response port holds its byte under back-pressure. A command is never accepted while a burst is pending, and a burst never outgrows its buffer. Every acceptance is followed by 0xFA. A parameter byte lands in the register selected by the preceding command, and the default-restore commands yield the default configuration.

Other behaviour can only be shown by the bench's directed scenarios, which read the configuration back through 0xE9 reports. These cover the exact content and order of each burst, and the point that the scaling clear keeps the reporting flag. They also cover that a parameter byte such as 0xF4 is not decoded as a command, and that unknown commands and bytes offered while busy leave the configuration untouched.

// File: rtl/ps2_mouse_pkg.sv
package ps2_mouse_pkg;

  localparam logic [7:0] BYTE_ACK       = 8'hFA;
  localparam logic [7:0] DEV_IDENT      = 8'h00;

  localparam logic [7:0] OP_SCALE_LIN   = 8'hE6;
  localparam logic [7:0] OP_SET_RES     = 8'hE8;
  localparam logic [7:0] OP_REPORT      = 8'hE9;
  localparam logic [7:0] OP_IDENT       = 8'hF2;
  localparam logic [7:0] OP_SET_RATE    = 8'hF3;
  localparam logic [7:0] OP_STREAM_ON   = 8'hF4;
  localparam logic [7:0] OP_STREAM_OFF  = 8'hF5;
  localparam logic [7:0] OP_DEFAULTS    = 8'hF6;
  localparam logic [7:0] OP_RESET       = 8'hFF;

  localparam int SCALE_BIT  = 4;
  localparam int REPORT_BIT = 5;

  typedef enum logic [1:0] {
    ARG_NONE = 2'd0,
    ARG_RES  = 2'd1,
    ARG_RATE = 2'd2
  } arg_mode_e;

endpackage

// File: rtl/mouse_cmd_decode.sv
module mouse_cmd_decode
  import ps2_mouse_pkg::*;
#(
  parameter int          DEPTH       = 4,
  parameter int          CNT_W       = 3,
  parameter logic [7:0]  RES_DEFAULT  = 8'h02,
  parameter logic [7:0]  RATE_DEFAULT = 8'd100
) (
  input  logic [7:0]                 in_byte,
  input  arg_mode_e                  arg_q,
  input  logic [7:0]                 status_q,
  input  logic [7:0]                 res_q,
  input  logic [7:0]                 rate_q,
  output logic [CNT_W-1:0]           burst_len,
  output logic [DEPTH-1:0][7:0]      burst_bytes,
  output arg_mode_e                  arg_d,
  output logic [7:0]                 status_d,
  output logic [7:0]                 res_d,
  output logic [7:0]                 rate_d
);

  always_comb begin
    burst_len      = CNT_W'(1);
    burst_bytes    = '0;
    burst_bytes[0] = BYTE_ACK;
    arg_d          = ARG_NONE;
    status_d       = status_q;
    res_d          = res_q;
    rate_d         = rate_q;

    if (arg_q == ARG_RES) begin
      res_d = in_byte;
    end else if (arg_q == ARG_RATE) begin
      rate_d = in_byte;
    end else begin
      case (in_byte)
        OP_SCALE_LIN:  status_d[SCALE_BIT] = 1'b0;
        OP_SET_RES:    arg_d = ARG_RES;
        OP_SET_RATE:   arg_d = ARG_RATE;
        OP_REPORT: begin
          burst_len      = CNT_W'(4);
          burst_bytes[1] = status_q;
          burst_bytes[2] = res_q;
          burst_bytes[3] = rate_q;
        end
        OP_IDENT: begin
          burst_len      = CNT_W'(2);
          burst_bytes[1] = DEV_IDENT;
        end
        OP_STREAM_ON:  status_d[REPORT_BIT] = 1'b1;
        OP_STREAM_OFF: status_d[REPORT_BIT] = 1'b0;
        OP_DEFAULTS, OP_RESET: begin
          status_d = 8'h00;
          res_d    = RES_DEFAULT;
          rate_d   = RATE_DEFAULT;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mouse_cfg_regs.sv
module mouse_cfg_regs
  import ps2_mouse_pkg::*;
#(
  parameter logic [7:0] RES_DEFAULT  = 8'h02,
  parameter logic [7:0] RATE_DEFAULT = 8'd100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_en,
  input  arg_mode_e  arg_d,
  input  logic [7:0] status_d,
  input  logic [7:0] res_d,
  input  logic [7:0] rate_d,
  output arg_mode_e  arg_q,
  output logic [7:0] status_q,
  output logic [7:0] res_q,
  output logic [7:0] rate_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q    <= ARG_NONE;
      status_q <= 8'h00;
      res_q    <= RES_DEFAULT;
      rate_q   <= RATE_DEFAULT;
    end else if (upd_en) begin
      arg_q    <= arg_d;
      status_q <= status_d;
      res_q    <= res_d;
      rate_q   <= rate_d;
    end
  end

  AST_ARG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    arg_q != 2'd3) else $error("illegal parameter-wait state"); // R8

endmodule

// File: rtl/mouse_rsp_seq.sv
module mouse_rsp_seq #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [CNT_W-1:0]      load_len,
  input  logic [DEPTH-1:0][7:0] load_bytes,
  input  logic                  pop,
  output logic [7:0]            head_byte,
  output logic                  busy
);

  logic [DEPTH-1:0][7:0] slot_q;
  logic [DEPTH-1:0][7:0] slot_d;
  logic [CNT_W-1:0]      cnt_q;
  logic [CNT_W-1:0]      cnt_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [7:0] shift_in;
    if (i == DEPTH - 1) begin : g_last
      assign shift_in = 8'h00;
    end else begin : g_mid
      assign shift_in = slot_q[i+1];
    end

    always_comb begin
      if (load)      slot_d[i] = load_bytes[i];
      else if (pop)  slot_d[i] = shift_in;
      else           slot_d[i] = slot_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[i] <= 8'h00;
      else        slot_q[i] <= slot_d[i];
    end
  end

  always_comb begin
    if (load)      cnt_d = load_len;
    else if (pop)  cnt_d = cnt_q - CNT_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy      = (cnt_q != '0);
  assign head_byte = slot_q[0];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)) else $error("burst count out of range"); // R11
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy) else $error("burst loaded over pending bytes"); // R10
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !load) |=> cnt_q == $past(cnt_q) - CNT_W'(1)) else $error("pop did not retire one byte"); // R11

endmodule

// File: rtl/ps2_mouse_responder.sv
module ps2_mouse_responder
  import ps2_mouse_pkg::*;
#(
  parameter int         RSP_DEPTH    = 4,
  parameter logic [7:0] RES_DEFAULT  = 8'h02,
  parameter logic [7:0] RATE_DEFAULT = 8'd100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_byte,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_byte
);

  localparam int CNT_W = $clog2(RSP_DEPTH + 1);

  logic                      rst_meta_q;
  logic                      rst_sync_n;
  logic                      take;
  logic                      busy;
  logic [CNT_W-1:0]          burst_len;
  logic [RSP_DEPTH-1:0][7:0] burst_bytes;
  arg_mode_e                 arg_q;
  arg_mode_e                 arg_d;
  logic [7:0]                status_q, status_d;
  logic [7:0]                res_q, res_d;
  logic [7:0]                rate_q, rate_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign cmd_ready = !busy;
  assign take      = cmd_valid && cmd_ready;
  assign rsp_valid = busy;

  mouse_cmd_decode #(
    .DEPTH        (RSP_DEPTH),
    .CNT_W        (CNT_W),
    .RES_DEFAULT  (RES_DEFAULT),
    .RATE_DEFAULT (RATE_DEFAULT)
  ) u_decode (
    .in_byte     (cmd_byte),
    .arg_q       (arg_q),
    .status_q    (status_q),
    .res_q       (res_q),
    .rate_q      (rate_q),
    .burst_len   (burst_len),
    .burst_bytes (burst_bytes),
    .arg_d       (arg_d),
    .status_d    (status_d),
    .res_d       (res_d),
    .rate_d      (rate_d)
  );

  mouse_cfg_regs #(
    .RES_DEFAULT  (RES_DEFAULT),
    .RATE_DEFAULT (RATE_DEFAULT)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd_en   (take),
    .arg_d    (arg_d),
    .status_d (status_d),
    .res_d    (res_d),
    .rate_d   (rate_d),
    .arg_q    (arg_q),
    .status_q (status_q),
    .res_q    (res_q),
    .rate_q   (rate_q)
  );

  mouse_rsp_seq #(
    .DEPTH (RSP_DEPTH),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (take),
    .load_len   (burst_len),
    .load_bytes (burst_bytes),
    .pop        (rsp_valid && rsp_ready),
    .head_byte  (rsp_byte),
    .busy       (busy)
  );

  AST_ACK_LEADS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    take |=> (rsp_valid && rsp_byte == BYTE_ACK)) else $error("burst does not open with ack"); // R2
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte))) else $error("response changed while stalled"); // R10
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> !cmd_ready) else $error("command port open during burst"); // R10
  AST_DEFAULTS_APPLIED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && arg_q == ARG_NONE && (cmd_byte == OP_DEFAULTS || cmd_byte == OP_RESET))
      |=> (status_q == 8'h00 && res_q == RES_DEFAULT && rate_q == RATE_DEFAULT)) else $error("defaults not restored"); // R7
  AST_RES_STORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && arg_q == ARG_RES) |=> (res_q == $past(cmd_byte) && arg_q == ARG_NONE)) else $error("resolution parameter lost"); // R8
  AST_RATE_STORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (take && arg_q == ARG_RATE) |=> (rate_q == $past(cmd_byte) && arg_q == ARG_NONE)) else $error("rate parameter lost"); // R8

endmodule

// File: tb/ps2_mouse_responder_tb.sv
module ps2_mouse_responder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [7:0] cmd_byte;
  logic       rsp_valid;
  logic       rsp_ready;
  logic [7:0] rsp_byte;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_mouse_responder u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_byte  (cmd_byte),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_byte  (rsp_byte)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Sends one byte and expects a burst of n bytes on consecutive cycles (R11).
  task automatic run_cmd(input logic [7:0] c, input int n,
                         input logic [7:0] e0, input logic [7:0] e1,
                         input logic [7:0] e2, input logic [7:0] e3,
                         input string req);
    logic [7:0] exp_b [4];
    exp_b[0] = e0; exp_b[1] = e1; exp_b[2] = e2; exp_b[3] = e3;
    send_byte(c);
    for (int i = 0; i < n; i++) begin
      check(rsp_valid === 1'b1 && rsp_byte === exp_b[i], req, {rsp_valid, rsp_byte}, {1'b1, exp_b[i]});
      @(negedge clk);
    end
    check(rsp_valid === 1'b0, {req, " R11 end"}, rsp_valid, 0);
  endtask

  task automatic expect_report(input logic [7:0] st, input logic [7:0] res,
                               input logic [7:0] rate, input string req);
    run_cmd(8'hE9, 4, 8'hFA, st, res, rate, req);
  endtask

  task automatic t_reset;
    check(cmd_ready === 1'b1, "R1 cmd_ready", cmd_ready, 1);
    check(rsp_valid === 1'b0, "R1 rsp_valid", rsp_valid, 0);
    expect_report(8'h00, 8'h02, 8'h64, "R1 R4 report after reset");
  endtask

  task automatic t_ident;
    run_cmd(8'hF2, 2, 8'hFA, 8'h00, 8'h00, 8'h00, "R5 R2 ident");
  endtask

  task automatic t_flags;
    run_cmd(8'hF4, 1, 8'hFA, 0, 0, 0, "R6 R2 stream on");
    expect_report(8'h20, 8'h02, 8'h64, "R6 report bit5 set");
    run_cmd(8'hE6, 1, 8'hFA, 0, 0, 0, "R3 R2 scale clear");
    expect_report(8'h20, 8'h02, 8'h64, "R3 bit4 clear bit5 kept");
    run_cmd(8'hF5, 1, 8'hFA, 0, 0, 0, "R6 stream off");
    expect_report(8'h00, 8'h02, 8'h64, "R6 report bit5 clear");
  endtask

  task automatic t_params;
    run_cmd(8'hE8, 1, 8'hFA, 0, 0, 0, "R8 R2 set res");
    run_cmd(8'h03, 1, 8'hFA, 0, 0, 0, "R8 res arg ack");
    expect_report(8'h00, 8'h03, 8'h64, "R8 res stored");
    run_cmd(8'hF3, 1, 8'hFA, 0, 0, 0, "R8 set rate");
    run_cmd(8'hF4, 1, 8'hFA, 0, 0, 0, "R8 rate arg ack");
    expect_report(8'h00, 8'h03, 8'hF4, "R8 rate stored, arg not decoded");
    run_cmd(8'hF3, 1, 8'hFA, 0, 0, 0, "R8 set rate again");
    run_cmd(8'hE9, 1, 8'hFA, 0, 0, 0, "R8 report code taken as arg");
    expect_report(8'h00, 8'h03, 8'hE9, "R8 rate holds E9");
  endtask

  task automatic t_unknown;
    run_cmd(8'hAA, 1, 8'hFA, 0, 0, 0, "R9 unknown ack only");
    run_cmd(8'hE7, 1, 8'hFA, 0, 0, 0, "R9 unknown E7 ack only");
    expect_report(8'h00, 8'h03, 8'hE9, "R9 config unchanged");
  endtask

  task automatic t_defaults;
    run_cmd(8'hF4, 1, 8'hFA, 0, 0, 0, "R7 prep");
    run_cmd(8'hFF, 1, 8'hFA, 0, 0, 0, "R7 reset cmd ack");
    expect_report(8'h00, 8'h02, 8'h64, "R7 after FF");
    run_cmd(8'hF4, 1, 8'hFA, 0, 0, 0, "R7 prep2");
    run_cmd(8'hE8, 1, 8'hFA, 0, 0, 0, "R7 prep3");
    run_cmd(8'h07, 1, 8'hFA, 0, 0, 0, "R7 prep4");
    run_cmd(8'hF6, 1, 8'hFA, 0, 0, 0, "R7 defaults cmd ack");
    expect_report(8'h00, 8'h02, 8'h64, "R7 after F6");
  endtask

  task automatic t_backpressure;
    rsp_ready = 1'b0;
    send_byte(8'hE9);
    cmd_valid = 1'b1;
    cmd_byte  = 8'hF4;
    for (int k = 0; k < 3; k++) begin
      check(rsp_valid === 1'b1 && rsp_byte === 8'hFA, "R10 hold under stall", rsp_byte, 8'hFA);
      check(cmd_ready === 1'b0, "R10 cmd_ready low while busy", cmd_ready, 0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    rsp_ready = 1'b1;
    check(rsp_byte === 8'hFA, "R10 resume ack", rsp_byte, 8'hFA);
    @(negedge clk);
    check(rsp_byte === 8'h00, "R10 resume status", rsp_byte, 8'h00);
    @(negedge clk);
    check(rsp_byte === 8'h02, "R10 resume res", rsp_byte, 8'h02);
    @(negedge clk);
    check(rsp_valid === 1'b1 && rsp_byte === 8'h64, "R10 resume rate", rsp_byte, 8'h64);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 burst done", rsp_valid, 0);
    expect_report(8'h00, 8'h02, 8'h64, "R10 busy offer ignored");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_byte  = 8'h00;
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ident();
    t_flags();
    t_params();
    t_unknown();
    t_defaults();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule